// File: doc/BRIEF.md
# Output-Compare Timer

This block is a timer peripheral built around a free-running counter that advances on a divided bus clock. Each of several compare channels holds a compare value. When the counter steps onto that value, the channel raises a sticky event flag. A flag can drive an interrupt request when the channel's interrupt enable is set, and all enabled requests are also ORed into one summary interrupt.

Software reaches every register through a simple synchronous bus with an address, write data, a write strobe, a read strobe and combinational read data. Flags are cleared in one of two ways. The first is by writing ones to the flag register. The second is available when the quick-clear option is on: any read or write of a channel's compare register also clears that channel's flag. This suits service routines that reload the compare value on every event.

The counter wraps. If a match is lost, for example because its flag was cleared before anyone serviced it, the channel fires again only after one full counter period.

Top module: `ocmp_timer`

## Requirements
- R1: After reset, every register reads zero (control, prescale, mode mask, enable mask, flags, counter, compare values) and no interrupt output is asserted.
- R2: The counter, read at address 5, advances by one on each tick and only while control bit 7 (run) is set. It wraps modulo 2^CNT_W. With bit 7 clear, it holds its value.
- R3: The prescale field, bits [2:0] at address 1, selects one counter tick every 2^N bus clocks. N = 3 gives one tick per 8 clocks.
- R4: A channel's flag, bit i at address 4, sets on the tick where the counter steps onto the channel's compare value (address 8+i). This happens only if bit i of the mode mask (address 2) is 1. While the counter keeps running, the same channel matches again exactly 2^CNT_W ticks later.
- R5: Several channels that match on the same tick each set their own flag in that cycle.
- R6: Writing address 4 clears each flag whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged.
- R7: When control bit 4 (quick clear) is 1, a read or a write of address 8+i clears flag i. When bit 4 is 0, such accesses leave the flags unchanged. Control reads back bits 7 and 4 as written, so writing 0x90 reads back 0x90.
- R8: The request for channel i is flag i AND bit i of the interrupt-enable mask (address 3). The summary interrupt is the OR of all channel requests.
- R9: A clear (by either method) and a new match on the same channel in the same cycle leave that flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe, takes effect on the rising clock edge |
| bus_rd | input | 1 | Read strobe (used for the quick-clear side effect) |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq_ch | output | NUM_CH | Per-channel interrupt requests |
| irq_any | output | 1 | OR of all channel requests |

## Verification
The bench builds the block with an 8-bit counter and four channels. A full counter period therefore lasts only 256 clocks, so the one-period recurrence of a lost match and the clear-versus-match collision on the exact wrap edge can both be reached and timed to the cycle. Four channels are enough to cover two channels matching together, a channel blocked by its mode bit, and a flagged channel whose interrupt is masked. The prescale check runs at a divide-by-8 setting over a window that is a whole number of tick periods, so the expected step count does not depend on the divider's phase.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

  // register addresses
  localparam int unsigned A_CTRL     = 0;
  localparam int unsigned A_PRESCALE = 1;
  localparam int unsigned A_MODE     = 2;
  localparam int unsigned A_IRQ_EN   = 3;
  localparam int unsigned A_FLAGS    = 4;
  localparam int unsigned A_COUNT    = 5;
  localparam int unsigned A_CMP_BASE = 8;

  // control bit positions
  localparam int unsigned RUN_BIT    = 7;
  localparam int unsigned QCLR_BIT   = 4;

  // low-bit mask that the divider must fill before a tick is issued
  function automatic int unsigned tick_mask(int unsigned sel);
    return (32'd1 << sel) - 32'd1;
  endfunction

  // sticky flag update: a new event wins over a clear in the same cycle
  function automatic logic flag_next(logic cur, logic set_ev, logic clr_ev);
    return set_ev | (cur & ~clr_ev);
  endfunction

endpackage

// File: rtl/ocmp_prescaler.sv
module ocmp_prescaler
  import ocmp_pkg::*;
#(
  parameter int unsigned PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned DIV_W = (1 << PRE_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb mask = DIV_W'(tick_mask(32'(sel)));

  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (run) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/ocmp_counter.sv
module ocmp_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);
  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= cnt_nxt;
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
  import ocmp_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic             cmp_mode,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             clr_ev,
  output logic             match_ev,
  output logic             flag_q
);
  assign match_ev = tick && cmp_mode && (cnt_nxt == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(flag_q, match_ev, clr_ev);
  end

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> flag_q);

  // R6
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !match_ev) |=> !flag_q);

  // R4
  rise_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(match_ev));
endmodule

// File: rtl/ocmp_timer.sv
module ocmp_timer
  import ocmp_pkg::*;
#(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PRE_W  = 3,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq_ch,
  output logic              irq_any
);
  logic              run_q, qclr_q;
  logic [PRE_W-1:0]  pre_q;
  logic [NUM_CH-1:0] mode_q, ien_q, flag_q, match_ev, clr_vec;
  logic [CNT_W-1:0]  cmp_q [NUM_CH];
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              tick;

  logic wr_ctrl, wr_pre, wr_mode, wr_ien, wr_flags, bus_acc;
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_pre   = bus_wr && (bus_addr == ADDR_W'(A_PRESCALE));
  assign wr_mode  = bus_wr && (bus_addr == ADDR_W'(A_MODE));
  assign wr_ien   = bus_wr && (bus_addr == ADDR_W'(A_IRQ_EN));
  assign wr_flags = bus_wr && (bus_addr == ADDR_W'(A_FLAGS));
  assign bus_acc  = bus_wr || bus_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      qclr_q <= 1'b0;
      pre_q  <= '0;
      mode_q <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= bus_wdata[RUN_BIT];
        qclr_q <= bus_wdata[QCLR_BIT];
      end
      if (wr_pre)  pre_q  <= bus_wdata[PRE_W-1:0];
      if (wr_mode) mode_q <= bus_wdata[NUM_CH-1:0];
      if (wr_ien)  ien_q  <= bus_wdata[NUM_CH-1:0];
    end
  end

  ocmp_prescaler #(.PRE_W(PRE_W)) i_prescaler (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run_q),
    .sel  (pre_q),
    .tick (tick)
  );

  ocmp_counter #(.CNT_W(CNT_W)) i_counter (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .cnt_q  (cnt_q),
    .cnt_nxt(cnt_nxt)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic cmp_hit;
    assign cmp_hit = (bus_addr == ADDR_W'(A_CMP_BASE + g));
    assign clr_vec[g] = (wr_flags && bus_wdata[g]) || (qclr_q && bus_acc && cmp_hit);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cmp_q[g] <= '0;
      else if (bus_wr && cmp_hit) cmp_q[g] <= bus_wdata[CNT_W-1:0];
    end

    ocmp_channel #(.CNT_W(CNT_W)) i_channel (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .cnt_nxt (cnt_nxt),
      .cmp_mode(mode_q[g]),
      .cmp_val (cmp_q[g]),
      .clr_ev  (clr_vec[g]),
      .match_ev(match_ev[g]),
      .flag_q  (flag_q[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(A_CTRL): begin
        bus_rdata[RUN_BIT]  = run_q;
        bus_rdata[QCLR_BIT] = qclr_q;
      end
      ADDR_W'(A_PRESCALE): bus_rdata = DATA_W'(pre_q);
      ADDR_W'(A_MODE):     bus_rdata = DATA_W'(mode_q);
      ADDR_W'(A_IRQ_EN):   bus_rdata = DATA_W'(ien_q);
      ADDR_W'(A_FLAGS):    bus_rdata = DATA_W'(flag_q);
      ADDR_W'(A_COUNT):    bus_rdata = DATA_W'(cnt_q);
      default: begin
        for (int i = 0; i < NUM_CH; i++)
          if (bus_addr == ADDR_W'(A_CMP_BASE + i)) bus_rdata = DATA_W'(cmp_q[i]);
      end
    endcase
  end

  assign irq_ch  = flag_q & ien_q;
  assign irq_any = |irq_ch;

  // R7
  qclr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!qclr_q && !wr_flags) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R2
  frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> $stable(cnt_q));
endmodule

// File: tb/test_ocmp_timer.sv
module test_ocmp_timer;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned PRE_W  = 3;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [DATA_W-1:0] bus_rdata;
  logic [NUM_CH-1:0] irq_ch;
  logic              irq_any;

  always #5 clk = ~clk;

  ocmp_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .PRE_W(PRE_W),
               .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ocmp_timer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_ch(irq_ch), .irq_any(irq_any)
  );

  typedef struct { int unsigned exp; string tag; } rd_item_t;
  rd_item_t sb_q[$];

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, int unsigned act, int unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data and compares, away from the clock edge
  always @(negedge clk) begin
    #2;
    if (bus_rd) begin
      rd_item_t it;
      if (sb_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: actual read with empty queue expected none");
      end else begin
        it = sb_q.pop_front();
        check(it.tag, int'(bus_rdata), it.exp);
      end
    end
  end

  // drivers, called at a falling edge, return at the next falling edge
  task automatic wr(int unsigned a, int unsigned d);
    bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int unsigned a, int unsigned exp, string tag);
    rd_item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_addr = ADDR_W'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(int unsigned a, output int unsigned v);
    bus_addr = ADDR_W'(a);
    #1 v = int'(bus_rdata);
  endtask

  task automatic wait_rise0();
    while (!irq_ch[0]) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    int t0, t1;
    int unsigned c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, 0, "R1 ctrl");
    rd(4, 0, "R1 flags");
    rd(5, 0, "R1 count");
    rd(8, 0, "R1 cmp0");
    check("R1 irq_any", irq_any, 0);

    wr(8, 40); wr(9, 40); wr(10, 100); wr(11, 41);
    wr(2, 4'b1011); wr(3, 4'b0011); wr(1, 0); wr(0, 8'h80);

    // R4 / R5 first match
    wait_rise0();
    t0 = cyc;
    check("R5 ch1 same tick", irq_ch[1], 1);
    rd(5, 40, "R4 count at match");
    rd(4, 32'h0B, "R5 flags after 41");
    check("R8 masked ch3", irq_ch[3], 0);
    check("R8 irq_any", irq_any, 1);

    // R6 write-one-to-clear
    wr(4, 32'h01);
    rd(4, 32'h0A, "R6 only bit0 cleared");
    wr(4, 32'h0A);
    rd(4, 0, "R6 all cleared");
    repeat (80) @(negedge clk);
    rd(4, 0, "R4 ch2 blocked by mode");

    // R7 quick clear
    wr(0, 8'h90);
    rd(0, 32'h90, "R7 ctrl readback");
    wait_rise0();
    t1 = cyc;
    check("R4 R2 recurrence after wrap", t1 - t0, 256);
    rd(8, 40, "R7 cmp0 read");
    rd(4, 32'h0A, "R7 read cleared ch0");
    wr(9, 40);
    rd(4, 32'h08, "R7 write cleared ch1");
    check("R8 only masked flag", irq_any, 0);
    wr(0, 8'h80);
    rd(11, 41, "R7 cmp3 read, quick clear off");
    wr(11, 41);
    rd(4, 32'h08, "R7 no clear when off");
    wr(3, 4'b1011);
    check("R8 ch3 request", irq_ch[3], 1);
    check("R8 irq_any on", irq_any, 1);
    wr(4, 32'hFF);
    rd(4, 0, "R6 clear all");

    // R9 clear collides with match
    wait_rise0();
    wr(4, 32'h01);
    repeat (254) @(negedge clk);
    wr(4, 32'h01);
    check("R9 irq_ch0 kept", irq_ch[0], 1);
    rd(4, 32'h0B, "R9 flags");

    // R3 prescale by 8
    wr(1, 3);
    peek(5, c0);
    repeat (80) @(negedge clk);
    rd(5, (c0 + 10) & 32'hFF, "R3 ten ticks in 80 clocks");

    // R2 stop
    wr(0, 0);
    peek(5, c0);
    repeat (30) @(negedge clk);
    rd(5, c0, "R2 counter frozen");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule